// File: doc/BRIEF.md
# Serial Register Port with Address Auto-Increment

This block is the target side of a four-wire serial link that gives a host read and write access to a local bank of 64 eight-bit registers. The host lowers an active-low select and shifts bytes in on a serial data line, most significant bit first. The first byte of every transfer is a command byte. It carries the direction, a stride flag and a 6-bit start address. The second byte is padding and is thrown away. Every complete byte that follows is either stored at the current address (write) or shifted back out of that address (read). The address then moves on by one or by two, depending on the stride flag, and wraps within the 64 entries.

Input bits are sampled on the rising edge of the serial clock. Output bits change on the falling edge, so the host can sample them on the next rising edge. The output is a data bit plus a separate drive enable. The enable is asserted only while a read is in its data phase with select low. Raising select ends the transfer at once: a partly shifted byte is dropped and the next transfer starts again with a command byte. The register bank lives inside the block. An asynchronous active-low reset clears it.

Top module: `sreg_port`

## Requirements
- R1: No register is written and the transfer state returns to the command byte whenever `cs_n` is high at a rising edge of `sck`.
- R2: `sdi` is sampled on the rising edge of `sck`, most significant bit first.
- R3: During a read, `sdo` changes on the falling edge of `sck` and presents each byte most significant bit first; the first data bit is valid after the falling edge that follows the last bit of the padding byte.
- R4: In the command byte, bit 7 selects the direction (0 = write, 1 = read), bit 6 is the stride flag and bits 5..0 are the start address.
- R5: All eight bits of the second header byte are ignored; any value gives the same transfer.
- R6: The first data byte uses the start address. Each further complete byte moves the address by 1 when the stride flag is 0, and by 2 when it is 1.
- R7: The advancing address wraps modulo 64.
- R8: `sdo_oe` is high only while `cs_n` is low and a read is in its data phase; it is low during the header, during writes and while `cs_n` is high.
- R9: A byte cut short by `cs_n` rising is discarded without any write, and the next transfer starts again with a command byte.
- R10: `rst_n` low clears all 64 registers to 0 and returns the port to the command byte.
- R11: A read returns the value last written to each address it visits, following the same address rule as writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; framing of a transfer |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means high impedance |

## Verification
The properties assume that `cs_n` and `sdi` only move away from rising edges of `sck`. They also assume that `sck` keeps toggling while `cs_n` is high, so that at least one rising edge sees the deselected state between two transfers. The bench changes every input one nanosecond after a falling edge and reads `sdo` at the same point. It holds `cs_n` high across a full clock period between transfers, including after the deliberately truncated byte. Reset is applied with select high and released away from any rising edge.

// File: rtl/sreg_port_pkg.sv
package sreg_port_pkg;
  localparam int ADDR_W_DEF = 6;
  localparam int DATA_W_DEF = 8;

  // Position of the transfer within the current select window
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_PAD  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/sreg_seq.sv
module sreg_seq
  import sreg_port_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              sck,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              wr_en,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              load_req,
  output logic              rd_phase,
  output logic              step_q
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-2:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  phase_e            phase;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] step_amt;
  logic [DATA_W-1:0] full;
  logic              byte_done;

  assign full      = {shreg, sdi};
  assign byte_done = !cs_n && (bit_cnt == LAST_BIT);
  assign step_amt  = step_q ? ADDR_W'(2) : ADDR_W'(1);
  assign wr_en     = byte_done && (phase == PH_DATA) && !rd_q;
  assign wr_data   = full;
  assign cur_addr  = addr_q;
  assign rd_phase  = (phase == PH_DATA) && rd_q;

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      phase    <= PH_CMD;
      rd_q     <= 1'b0;
      step_q   <= 1'b0;
      addr_q   <= '0;
      load_req <= 1'b0;
    end else if (cs_n) begin
      bit_cnt  <= '0;
      phase    <= PH_CMD;
      load_req <= 1'b0;
    end else begin
      shreg    <= full[DATA_W-2:0];
      bit_cnt  <= bit_cnt + 1'b1;
      load_req <= 1'b0;
      if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            rd_q   <= full[DATA_W-1];
            step_q <= full[DATA_W-2];
            addr_q <= full[ADDR_W-1:0];
            phase  <= PH_PAD;
          end
          PH_PAD: begin
            phase    <= PH_DATA;
            load_req <= rd_q;
          end
          default: begin
            addr_q   <= addr_q + step_amt;
            load_req <= rd_q;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_port_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              sck,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx
  import sreg_port_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              sck,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              load_req,
  input  logic              rd_phase,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdo
);
  logic [DATA_W-1:0] sr;

  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n)                sr <= '0;
    else if (load_req)         sr <= rd_data;
    else if (rd_phase && !cs_n) sr <= {sr[DATA_W-2:0], 1'b0};
  end

  assign sdo = sr[DATA_W-1];
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_port_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  logic              wr_en;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              load_req;
  logic              rd_phase;
  logic              step_q;

  sreg_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
    .wr_en(wr_en), .cur_addr(cur_addr), .wr_data(wr_data),
    .load_req(load_req), .rd_phase(rd_phase), .step_q(step_q)
  );

  sreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .sck(sck), .rst_n(rst_n), .wr_en(wr_en), .addr(cur_addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  sreg_tx #(.DATA_W(DATA_W)) u_tx (
    .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .load_req(load_req),
    .rd_phase(rd_phase), .rd_data(rd_data), .sdo(sdo)
  );

  assign sdo_oe = !cs_n && rd_phase;
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk #(
  parameter int ADDR_W = 6
) (
  input logic              sck,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sdo_oe,
  input logic              wr_en,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              step_q
);
  logic              prev_ok;
  logic [ADDR_W-1:0] prev_addr;

  p_oe_needs_cs_r8: assert property (@(posedge sck) disable iff (!rst_n)
    cs_n |-> !sdo_oe);

  p_no_write_deselected_r1: assert property (@(posedge sck) disable iff (!rst_n)
    cs_n |-> !wr_en);

  p_byte_spacing_r2: assert property (@(posedge sck) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_restart_after_cs_r9: assert property (@(posedge sck) disable iff (!rst_n)
    cs_n |=> !wr_en);

  // Consecutive writes in one select window follow the stride rule (R6, R7)
  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      prev_ok   <= 1'b0;
      prev_addr <= '0;
    end else if (cs_n) begin
      prev_ok <= 1'b0;
    end else if (wr_en) begin
      if (prev_ok) begin
        p_addr_stride_r6: assert (cur_addr == prev_addr + (step_q ? ADDR_W'(2) : ADDR_W'(1)));
      end
      prev_ok   <= 1'b1;
      prev_addr <= cur_addr;
    end
  end
endmodule

bind sreg_port sreg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe),
  .wr_en(wr_en), .cur_addr(cur_addr), .step_q(step_q)
);

// File: tb/sreg_port_test.sv
module sreg_port_test;
  logic sck = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;
  int checks = 0;
  int errors = 0;
  logic [7:0] model [64];

  // Rows: {cmd, pad, d0, d1, d2, count}
  localparam logic [47:0] VEC [6] = '{
    {8'h00, 8'hFF, 8'h11, 8'h22, 8'h33, 8'd3},  // step 1 from 0
    {8'h4A, 8'hA5, 8'h44, 8'h55, 8'h66, 8'd3},  // step 2 from 10
    {8'h3E, 8'h00, 8'h77, 8'h88, 8'h99, 8'd3},  // step 1 wrap 62,63,0
    {8'h7F, 8'h5A, 8'hAA, 8'hBB, 8'hCC, 8'd3},  // step 2 wrap 63,1,3
    {8'h14, 8'hC3, 8'hDD, 8'h00, 8'h00, 8'd1},  // single at 20
    {8'h1E, 8'h81, 8'hEE, 8'h5A, 8'h00, 8'd2}   // step 1 from 30
  };

  always #4 sck = ~sck;

  sreg_port uut (
    .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge sck); #1;
      rx[i]  = sdo;
      oe_any = oe_any | sdo_oe;
      cs_n   = 1'b0;
      sdi    = tx[i];
    end
  endtask

  task automatic end_xfer();
    @(negedge sck); #1;
    cs_n = 1'b1;
    sdi  = 1'b0;
    @(posedge sck); #1;
  endtask

  task automatic do_read(input logic [5:0] a0, input bit stride2, input int n,
                         input logic [7:0] pad, input string req);
    logic [7:0] rx;
    logic oe;
    logic oe_hdr;
    logic [5:0] a;
    a = a0;
    xbyte({1'b1, stride2, a0}, rx, oe);
    oe_hdr = oe;
    xbyte(pad, rx, oe);
    oe_hdr = oe_hdr | oe;
    check(!oe_hdr, "R8 oe during header", int'(oe_hdr), 0);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, rx, oe);
      check(rx == model[a], req, rx, model[a]);
      check(oe, "R8 oe during read data", int'(oe), 1);
      a = a + (stride2 ? 6'd2 : 6'd1);
    end
    end_xfer();
    check(!sdo_oe, "R8 oe after deselect", int'(sdo_oe), 0);
  endtask

  initial begin
    logic [7:0] rx;
    logic oe;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(posedge sck);
    @(negedge sck); #1;
    check(!sdo_oe, "R10 oe in reset", int'(sdo_oe), 0);
    rst_n = 1'b1;
    @(negedge sck); #1;

    // R10: registers read zero after reset
    do_read(6'd7, 1'b0, 2, 8'h00, "R10 reset value");

    // Table walk: writes with both strides, wraps and ignored pad bytes (R2 R4 R5 R6 R7)
    for (int r = 0; r < 6; r++) begin
      logic [5:0] a;
      logic oe_w;
      int n;
      a    = VEC[r][45:40];
      n    = int'(VEC[r][7:0]);
      oe_w = 1'b0;
      xbyte(VEC[r][47:40], rx, oe); oe_w = oe_w | oe;
      xbyte(VEC[r][39:32], rx, oe); oe_w = oe_w | oe;
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        d = VEC[r][31 - 8*k -: 8];
        xbyte(d, rx, oe); oe_w = oe_w | oe;
        model[a] = d;
        a = a + (VEC[r][46] ? 6'd2 : 6'd1);
      end
      end_xfer();
      check(!oe_w, "R8 oe during write", int'(oe_w), 0);
    end

    // Full sweep read back (R11 R3 R6 R7 R5)
    do_read(6'd0, 1'b0, 64, 8'h3C, "R11 R3 sweep readback");
    // Stride 2 read with wrap (R6 R7)
    do_read(6'd60, 1'b1, 4, 8'hFF, "R7 R6 stride2 read wrap");

    // R9: truncated byte is dropped
    xbyte(8'h05, rx, oe);
    xbyte(8'h00, rx, oe);
    for (int i = 0; i < 3; i++) begin
      @(negedge sck); #1; sdi = 1'b1;
    end
    end_xfer();
    do_read(6'd5, 1'b0, 1, 8'h00, "R9 partial byte discarded");
    // R9/R1: next transfer parses a fresh command byte
    xbyte(8'h06, rx, oe);
    xbyte(8'h77, rx, oe);
    xbyte(8'h3C, rx, oe);
    end_xfer();
    model[6] = 8'h3C;
    do_read(6'd5, 1'b0, 2, 8'h00, "R1 R9 fresh transfer after abort");

    // R10: reset mid-run clears the bank
    @(negedge sck); #1; rst_n = 1'b0;
    @(negedge sck); #1; rst_n = 1'b1;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    do_read(6'd0, 1'b0, 64, 8'h00, "R10 cleared after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge sck);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule